// File: doc/BRIEF.md
# VLIW Issue Constraint Checker

This block sits beside the issue stage of a five-slot VLIW core. It checks every group of operations issued in one cycle against two scheduling rules. Each slot presents a valid bit and a 4-bit functional-unit type. From the type the block finds the unit's latency and its recovery time. It then tests two things. First, every unit the group uses must have recovered from its last issue. Second, the results the group adds must not push any future writeback cycle above five results.

A legal, non-empty group is accepted and committed into the tracking state. Committing sets a busy counter for the unit and adds one result count per operation in the writeback pipeline, at the slot for that operation's latency. A group that breaks any rule is rejected whole and nothing from it is committed. For every non-empty group the block reports, in the next cycle, an accept pulse or an error pulse. The error pulse comes with a code that names the broken rule. The block also shows each unit's ready state and the number of results landing in the current cycle, so a scheduler or a bench can follow the tracked state.

The immediate unit has a fixed latency of one cycle and the floating add/convert unit a fixed latency of three. All other latencies, and the recovery time of the iterative divide/root unit, are parameters.

Top module: `vliw_issue_guard`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears all tracking state. After it, grp_accept and grp_error are 0, err_code is 0, wb_land_cnt is 0 and unit_ready is all ones.
- R2: Type codes are 0 imm, 1 alu, 2 simd-alu, 3 simd-mul, 4 load/store, 5 cache-op, 6 shift, 7 branch, 8 fp-add, 9 mul, 10 fp-compare, 11 fp-iterative. A valid slot carrying code 12 to 15 rejects the group with err_code 3.
- R3: A result is counted in wb_land_cnt exactly its latency in cycles after its issue cycle. The latencies are imm 1 and fp-add 3, and by default alu 1, simd-alu 2, simd-mul 3, load/store 3, cache-op 3, shift 1, branch 3, mul 3, fp-compare 1 and fp-iterative 17.
- R4: After an accepted fp-iterative issue in cycle t, any group with an fp-iterative op is rejected with err_code 1 until cycle t+REC_FPITER (default 17), and accepted from that cycle on. All other units accept every cycle, and several slots may use the same such unit in one group.
- R5: A group holding two or more fp-iterative ops is rejected with err_code 1.
- R6: A group that would make more than five results land in one cycle is rejected with err_code 2. wb_land_cnt never exceeds five.
- R7: A rejected group commits nothing: no busy counter and no writeback count changes.
- R8: The outcome of the group presented before clock edge E appears on the outputs after E, for one cycle. grp_accept and grp_error are never high together. err_code is 1 for recovery, 2 for writeback and 3 for an illegal type, with priority illegal type, then recovery, then writeback, and is 0 when grp_error is low.
- R9: Slots with a low valid bit are ignored whatever their type. A group with no valid slot raises neither pulse.
- R10: unit_ready[u] is 1 exactly when unit u may accept an issue in the current cycle. It falls only in the cycle that shows the accept of the issue that made the unit busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_vld | input | NSLOT | Per-slot valid bits |
| slot_type | input | 4*NSLOT | Per-slot unit type codes, slot s in bits [4s+3:4s] |
| grp_accept | output | 1 | Pulse: the previous cycle's group was accepted |
| grp_error | output | 1 | Pulse: the previous cycle's group was rejected |
| err_code | output | 2 | Broken rule: 1 recovery, 2 writeback, 3 illegal type |
| unit_ready | output | 12 | Per-unit ready state, bit index is the type code |
| wb_land_cnt | output | clog2(WB_MAX+1) | Results landing in the current cycle |

## Verification
A wrong busy counter shows at once on unit_ready. It also shows at the first fp-iterative attempt after the recovery window, which is accepted one cycle too early or too late. A mis-shifted or mis-incremented writeback slot shows on wb_land_cnt in the exact cycle the result should land, at most seventeen cycles after issue. It also shows as an overflow code on a later group that should have fitted. A wrongly committed rejected group shows within one latency as an extra landing count, or as a unit that drops out of ready.

// File: rtl/vig_pkg.sv
package vig_pkg;
    localparam int NTYPE  = 12;
    localparam int TYPE_W = 4;

    typedef enum logic [TYPE_W-1:0] {
        U_IMM     = 4'd0,
        U_ALU     = 4'd1,
        U_SIMDALU = 4'd2,
        U_SIMDMUL = 4'd3,
        U_LDST    = 4'd4,
        U_CACHEOP = 4'd5,
        U_SHIFT   = 4'd6,
        U_BRANCH  = 4'd7,
        U_FPADD   = 4'd8,
        U_MUL     = 4'd9,
        U_FPCMP   = 4'd10,
        U_FPITER  = 4'd11
    } unit_e;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_RECOVERY = 2'd1,
        ERR_WBFULL   = 2'd2,
        ERR_BADTYPE  = 2'd3
    } err_e;
endpackage

// File: rtl/vig_slot_decode.sv
module vig_slot_decode #(
    parameter int NTYPE = 12,
    parameter int TW = 4,
    parameter int LW = 5,
    parameter logic [NTYPE*LW-1:0] LAT_TAB = '0
) (
    input  logic          vld,
    input  logic [TW-1:0] code,
    output logic          ok,
    output logic          bad,
    output logic [LW-1:0] lat
);
    logic legal;

    always_comb begin
        legal = (int'(code) < NTYPE);
        ok    = vld && legal;
        bad   = vld && !legal;
        lat   = '0;
        if (legal) begin
            lat = LAT_TAB[int'(code)*LW +: LW];
        end
    end
endmodule

// File: rtl/vig_recovery_trk.sv
module vig_recovery_trk #(
    parameter int NSLOT = 5,
    parameter int NTYPE = 12,
    parameter int TW = 4,
    parameter int RW = 5,
    parameter logic [NTYPE*RW-1:0] REC_TAB = '0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NSLOT-1:0]          slot_ok,
    input  logic [NSLOT-1:0][TW-1:0]  slot_code,
    input  logic                      commit,
    output logic                      conflict,
    output logic [NTYPE-1:0]          ready
);
    localparam int CNTW = $clog2(NSLOT + 1);

    typedef struct packed {
        logic [NTYPE-1:0][RW-1:0] busy;
    } rec_state_t;

    rec_state_t s_d, s_q;
    logic [NTYPE-1:0][CNTW-1:0] use_cnt;

    function automatic int rec_of(int t);
        return int'(REC_TAB[t*RW +: RW]);
    endfunction

    always_comb begin
        conflict = 1'b0;
        for (int t = 0; t < NTYPE; t++) begin
            use_cnt[t] = '0;
            for (int s = 0; s < NSLOT; s++) begin
                if (slot_ok[s] && (int'(slot_code[s]) == t)) begin
                    use_cnt[t] = use_cnt[t] + CNTW'(1);
                end
            end
            if ((use_cnt[t] != '0) && (s_q.busy[t] != '0)) begin
                conflict = 1'b1;
            end
            if ((rec_of(t) > 1) && (int'(use_cnt[t]) > 1)) begin
                conflict = 1'b1;
            end
        end
    end

    always_comb begin
        s_d = s_q;
        for (int t = 0; t < NTYPE; t++) begin
            if (s_q.busy[t] != '0) begin
                s_d.busy[t] = s_q.busy[t] - RW'(1);
            end
            if (commit && (use_cnt[t] != '0) && (rec_of(t) > 1)) begin
                s_d.busy[t] = RW'(rec_of(t) - 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < NTYPE; g++) begin : g_ready
        assign ready[g] = (s_q.busy[g] == '0);
    end
endmodule

// File: rtl/vig_wb_trk.sv
module vig_wb_trk #(
    parameter int NSLOT = 5,
    parameter int LW = 5,
    parameter int MAXLAT = 17,
    parameter int WB_MAX = 5,
    parameter int CW = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NSLOT-1:0]          slot_ok,
    input  logic [NSLOT-1:0][LW-1:0]  slot_lat,
    input  logic                      commit,
    output logic                      overflow,
    output logic [CW-1:0]             land_cnt
);
    localparam int AW = $clog2(NSLOT + 1);

    typedef struct packed {
        logic [MAXLAT:0][CW-1:0] slot;
    } wb_state_t;

    wb_state_t s_d, s_q;
    logic [MAXLAT:0][AW-1:0] add;

    always_comb begin
        overflow = 1'b0;
        for (int k = 0; k <= MAXLAT; k++) begin
            add[k] = '0;
            for (int s = 0; s < NSLOT; s++) begin
                if (slot_ok[s] && (int'(slot_lat[s]) == k)) begin
                    add[k] = add[k] + AW'(1);
                end
            end
            if ((int'(s_q.slot[k]) + int'(add[k])) > WB_MAX) begin
                overflow = 1'b1;
            end
        end
    end

    always_comb begin
        s_d = s_q;
        for (int j = 0; j < MAXLAT; j++) begin
            s_d.slot[j] = s_q.slot[j+1];
            if (commit) begin
                s_d.slot[j] = s_q.slot[j+1] + CW'(add[j+1]);
            end
        end
        s_d.slot[MAXLAT] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign land_cnt = s_q.slot[0];
endmodule

// File: rtl/vliw_issue_guard.sv
module vliw_issue_guard
    import vig_pkg::*;
#(
    parameter int NSLOT       = 5,
    parameter int WB_MAX      = 5,
    parameter int LAT_ALU     = 1,
    parameter int LAT_SIMDALU = 2,
    parameter int LAT_SIMDMUL = 3,
    parameter int LAT_LDST    = 3,
    parameter int LAT_CACHEOP = 3,
    parameter int LAT_SHIFT   = 1,
    parameter int LAT_BRANCH  = 3,
    parameter int LAT_MUL     = 3,
    parameter int LAT_FPCMP   = 1,
    parameter int LAT_FPITER  = 17,
    parameter int REC_FPITER  = 17
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NSLOT-1:0]                slot_vld,
    input  logic [NSLOT*TYPE_W-1:0]         slot_type,
    output logic                            grp_accept,
    output logic                            grp_error,
    output logic [1:0]                      err_code,
    output logic [NTYPE-1:0]                unit_ready,
    output logic [$clog2(WB_MAX+1)-1:0]     wb_land_cnt
);
    localparam int LAT_IMM   = 1;
    localparam int LAT_FPADD = 3;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int MAXLAT = imax(imax(imax(imax(LAT_IMM, LAT_ALU), imax(LAT_SIMDALU, LAT_SIMDMUL)),
                                      imax(imax(LAT_LDST, LAT_CACHEOP), imax(LAT_SHIFT, LAT_BRANCH))),
                                 imax(imax(LAT_FPADD, LAT_MUL), imax(LAT_FPCMP, LAT_FPITER)));
    localparam int LW = $clog2(MAXLAT + 1);
    localparam int RW = $clog2(imax(REC_FPITER, 1) + 1);
    localparam int CW = $clog2(WB_MAX + 1);

    localparam logic [NTYPE*LW-1:0] LAT_TAB = {
        LW'(LAT_FPITER), LW'(LAT_FPCMP), LW'(LAT_MUL), LW'(LAT_FPADD),
        LW'(LAT_BRANCH), LW'(LAT_SHIFT), LW'(LAT_CACHEOP), LW'(LAT_LDST),
        LW'(LAT_SIMDMUL), LW'(LAT_SIMDALU), LW'(LAT_ALU), LW'(LAT_IMM)
    };
    localparam logic [NTYPE*RW-1:0] REC_TAB = {RW'(REC_FPITER), {(NTYPE-1){RW'(1)}}};

    typedef struct packed {
        logic       accept;
        logic       error;
        logic [1:0] code;
    } out_t;

    out_t o_d, o_q;

    logic [NSLOT-1:0]             slot_ok;
    logic [NSLOT-1:0]             slot_bad;
    logic [NSLOT-1:0][LW-1:0]     slot_lat;
    logic [NSLOT-1:0][TYPE_W-1:0] slot_code;
    logic                         conflict;
    logic                         overflow;
    logic                         commit;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign slot_code[s] = slot_type[s*TYPE_W +: TYPE_W];
        vig_slot_decode #(
            .NTYPE(NTYPE), .TW(TYPE_W), .LW(LW), .LAT_TAB(LAT_TAB)
        ) u_dec (
            .vld  (slot_vld[s]),
            .code (slot_code[s]),
            .ok   (slot_ok[s]),
            .bad  (slot_bad[s]),
            .lat  (slot_lat[s])
        );
    end

    vig_recovery_trk #(
        .NSLOT(NSLOT), .NTYPE(NTYPE), .TW(TYPE_W), .RW(RW), .REC_TAB(REC_TAB)
    ) u_rec (
        .clk       (clk),
        .rst       (rst),
        .slot_ok   (slot_ok),
        .slot_code (slot_code),
        .commit    (commit),
        .conflict  (conflict),
        .ready     (unit_ready)
    );

    vig_wb_trk #(
        .NSLOT(NSLOT), .LW(LW), .MAXLAT(MAXLAT), .WB_MAX(WB_MAX), .CW(CW)
    ) u_wb (
        .clk      (clk),
        .rst      (rst),
        .slot_ok  (slot_ok),
        .slot_lat (slot_lat),
        .commit   (commit),
        .overflow (overflow),
        .land_cnt (wb_land_cnt)
    );

    always_comb begin
        logic any_vld;
        logic any_bad;
        any_vld  = |slot_vld;
        any_bad  = |slot_bad;
        commit   = any_vld && !any_bad && !conflict && !overflow;
        o_d      = '0;
        o_d.accept = commit;
        o_d.error  = any_vld && !commit;
        if (o_d.error) begin
            if (any_bad) begin
                o_d.code = ERR_BADTYPE;
            end else if (conflict) begin
                o_d.code = ERR_RECOVERY;
            end else begin
                o_d.code = ERR_WBFULL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign grp_accept = o_q.accept;
    assign grp_error  = o_q.error;
    assign err_code   = o_q.code;
endmodule

// File: rtl/vig_guard_chk.sv
module vig_guard_chk #(
    parameter int NSLOT = 5,
    parameter int NTYPE = 12,
    parameter int WB_MAX = 5,
    parameter int CW = 3,
    parameter int ITER_IDX = 11
) (
    input logic             clk,
    input logic             rst,
    input logic [NSLOT-1:0] slot_vld,
    input logic             grp_accept,
    input logic             grp_error,
    input logic [1:0]       err_code,
    input logic [NTYPE-1:0] unit_ready,
    input logic [CW-1:0]    wb_land_cnt
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wb_land_cnt == '0 && !grp_accept && !grp_error && (&unit_ready)));

    // R8
    accept_error_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(grp_accept && grp_error));

    // R8
    accept_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
        grp_accept |-> (err_code == 2'd0));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        int'(wb_land_cnt) <= WB_MAX);

    // R10
    ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(unit_ready[ITER_IDX]) |-> grp_accept);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(slot_vld) == '0) |-> (!grp_accept && !grp_error));
endmodule

bind vliw_issue_guard vig_guard_chk #(
    .NSLOT(NSLOT), .NTYPE(vig_pkg::NTYPE), .WB_MAX(WB_MAX), .CW($clog2(WB_MAX+1)), .ITER_IDX(11)
) u_guard_chk (
    .clk         (clk),
    .rst         (rst),
    .slot_vld    (slot_vld),
    .grp_accept  (grp_accept),
    .grp_error   (grp_error),
    .err_code    (err_code),
    .unit_ready  (unit_ready),
    .wb_land_cnt (wb_land_cnt)
);

// File: tb/tb_vliw_issue_guard.sv
module tb_vliw_issue_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  slot_vld = '0;
    logic [19:0] slot_type = '0;
    logic        grp_accept;
    logic        grp_error;
    logic [1:0]  err_code;
    logic [11:0] unit_ready;
    logic [2:0]  wb_land_cnt;

    int nchk = 0;
    int nfail = 0;

    localparam int ITER = 11;

    always #5 clk = ~clk;

    vliw_issue_guard dut (
        .clk(clk), .rst(rst), .slot_vld(slot_vld), .slot_type(slot_type),
        .grp_accept(grp_accept), .grp_error(grp_error), .err_code(err_code),
        .unit_ready(unit_ready), .wb_land_cnt(wb_land_cnt)
    );

    function automatic int lat_of(int c);
        case (c)
            0, 1, 6, 10: return 1;
            2:           return 2;
            11:          return 17;
            default:     return 3;
        endcase
    endfunction

    function automatic logic [19:0] pk(int a, int b, int c, int d, int e);
        return {4'(e), 4'(d), 4'(c), 4'(b), 4'(a)};
    endfunction

    task automatic check(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(logic [4:0] v, logic [19:0] t);
        slot_vld = v;
        slot_type = t;
        @(posedge clk);
        #2;
        slot_vld = '0;
        slot_type = 20'hFFFFF;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic expect_acc(string req);
        check({req, " accept"}, int'(grp_accept), 1);
        check({req, " error"}, int'(grp_error), 0);
    endtask

    task automatic expect_err(string req, int code);
        check({req, " accept"}, int'(grp_accept), 0);
        check({req, " error"}, int'(grp_error), 1);
        check({req, " code"}, int'(err_code), code);
    endtask

    initial begin
        #2_000_000;
        nfail++;
        nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        idle(1);
        // R1 reset state
        check("R1 accept", int'(grp_accept), 0);
        check("R1 error", int'(grp_error), 0);
        check("R1 code", int'(err_code), 0);
        check("R1 land", int'(wb_land_cnt), 0);
        check("R1 ready", int'(unit_ready), 12'hFFF);

        // R2 R3 sweep over every legal type
        for (int c = 0; c < 12; c++) begin
            int l;
            l = lat_of(c);
            issue(5'b00001, pk(c, 0, 0, 0, 0));
            expect_acc("R2");
            if (c == ITER) check("R10 busy after accept", int'(unit_ready[ITER]), 0);
            if (l > 1) begin
                idle(l - 2);
                check("R3 before landing", int'(wb_land_cnt), 0);
                idle(1);
            end
            check("R3 landing", int'(wb_land_cnt), 1);
            idle(1);
            check("R3 after landing", int'(wb_land_cnt), 0);
            idle(18);
        end

        // R2 illegal codes, R7 nothing committed
        for (int c = 12; c < 16; c++) begin
            issue(5'b00011, pk(1, c, 0, 0, 0));
            expect_err("R2 illegal", 3);
            check("R7 no alu landing", int'(wb_land_cnt), 0);
        end

        // R4 recovery window of the iterative unit
        issue(5'b00001, pk(ITER, 0, 0, 0, 0));
        expect_acc("R4 first");
        for (int k = 1; k <= 16; k++) begin
            if (k == 5) begin
                issue(5'b11111, pk(1, 1, 1, 1, 1));
                expect_acc("R4 alu while busy");
            end else begin
                if (k == 16) check("R10 still busy", int'(unit_ready[ITER]), 0);
                issue(5'b00001, pk(ITER, 0, 0, 0, 0));
                expect_err("R4 early", 1);
            end
        end
        check("R10 ready at window end", int'(unit_ready[ITER]), 1);
        issue(5'b00001, pk(ITER, 0, 0, 0, 0));
        expect_acc("R4 at window end");
        idle(20);

        // R5 two iterative ops in one group
        issue(5'b00101, pk(ITER, 0, ITER, 0, 0));
        expect_err("R5", 1);
        check("R7 ready kept", int'(unit_ready[ITER]), 1);
        idle(2);

        // R6 overflow, R7 no commit
        issue(5'b11111, pk(8, 8, 8, 8, 8));
        expect_acc("R6 five fpadd");
        issue(5'b00001, pk(2, 0, 0, 0, 0));
        expect_err("R6 simdalu", 2);
        issue(5'b00001, pk(6, 0, 0, 0, 0));
        expect_err("R6 shift", 2);
        check("R7 land five", int'(wb_land_cnt), 5);
        idle(1);
        check("R6 land drained", int'(wb_land_cnt), 0);
        idle(4);

        issue(5'b00111, pk(8, 8, 8, 0, 0));
        expect_acc("R6 three fpadd");
        issue(5'b00011, pk(2, 2, 0, 0, 0));
        expect_acc("R6 fill to five");
        issue(5'b00001, pk(1, 0, 0, 0, 0));
        expect_err("R6 sixth", 2);
        check("R6 land five", int'(wb_land_cnt), 5);
        idle(5);

        // R8 priority
        issue(5'b00001, pk(ITER, 0, 0, 0, 0));
        expect_acc("R8 setup");
        issue(5'b00011, pk(ITER, 13, 0, 0, 0));
        expect_err("R8 bad over recovery", 3);
        idle(20);
        issue(5'b11111, pk(ITER, 8, 8, 8, 8));
        expect_acc("R8 setup two");
        issue(5'b00111, pk(ITER, 2, 2, 0, 0));
        expect_err("R8 recovery over writeback", 1);
        idle(20);

        // R9 invalid slots ignored
        issue(5'b00000, pk(15, 15, 15, 15, 15));
        check("R9 empty accept", int'(grp_accept), 0);
        check("R9 empty error", int'(grp_error), 0);
        issue(5'b00010, pk(14, 1, 15, 15, 15));
        expect_acc("R9 masked bad");
        idle(2);

        // R1 reset mid-flight
        issue(5'b00011, pk(ITER, 8, 0, 0, 0));
        expect_acc("R1 setup");
        rst = 1'b1;
        @(posedge clk);
        #2;
        rst = 1'b0;
        check("R1 ready cleared", int'(unit_ready), 12'hFFF);
        check("R1 land cleared", int'(wb_land_cnt), 0);
        idle(1);
        check("R1 pending dropped", int'(wb_land_cnt), 0);
        issue(5'b00001, pk(ITER, 0, 0, 0, 0));
        expect_acc("R1 unit free");

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule